// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block tracks interrupts for a small group of CPUs (up to four). It keeps two pending vectors, one bit per CPU in each. The first holds inter-processor interrupts (IPIs). The second holds periodic timer interrupts. Each pending bit drives its own interrupt line to its CPU. A third level per CPU carries a shared device interrupt, which is broadcast to every CPU.

Software reaches the block through a word-indexed register port. One control register can do three things in a single write: post IPIs, clear IPIs and clear timer interrupts. Each of these has its own 4-bit CPU field. There are also dedicated registers that read the pending vectors, clear selected bits, and post IPIs from a mask. A reading CPU identifies itself on `req_cpu_i`, and the control register returns that ID in its readback.

An external tick input marks every CPU's timer interrupt as pending. Some writes are redundant: posting an IPI that is already pending, or clearing one that is not. These change nothing and raise a one-cycle warning. Malformed writes change nothing and raise a one-cycle error.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset, every pending bit is zero, and every IPI line, timer line, warning and error output is low.
- R2: A write to the control register (offset 0) handles three fields. Bits 15:12 post IPIs to the CPUs whose bits are set. Bits 11:8 clear those CPUs' IPIs. Bits 7:4 clear those CPUs' timer interrupts. All three fields take effect in the same write. Within the IPI vector, the post is applied first and the clear second, so a simultaneous post and clear of one CPU leaves its IPI clear.
- R3: Posting an IPI to a CPU that already has one pending raises the warning output. Clearing an IPI for a CPU with none pending (after that write's own post) also raises the warning output. In both cases that bit's state is left as it was.
- R4: A high `tick_i` sets the timer-pending bit of every CPU. If the same cycle also clears a timer bit, the tick wins and the bit ends up set.
- R5: A control-register write with all three fields zero and bit 28 clear raises the error output and changes no state. With bit 28 set, the same write is a silent acknowledge: it raises no error and changes no state.
- R6: Dedicated registers: a write to offset 1 clears the IPI bits given in data bits 3:0, a write to offset 2 clears those timer bits, and a write to offset 3 posts those IPIs. A read of offset 1 or offset 2 returns the IPI or timer pending vector in bits 3:0. A read of offset 3 returns zero.
- R7: A write to offset 1, 2 or 3 with data bits 3:0 all zero, or a write to any other offset, raises the error output and changes no pending bit.
- R8: A read of offset 0 returns the pending IPIs in bits 11:8, the pending timer interrupts in bits 7:4 and `req_cpu_i` in bits 1:0. All other bits read as zero. Reads are combinational in the same cycle.
- R9: Every CPU's device interrupt line follows `dev_irq_i` in the same cycle.
- R10: The pending state and the warning and error flags all update on the clock edge that samples the write. The flags are high for exactly that one following cycle unless the next write also triggers them.
- R11: CPU mask bits at or above the configured CPU count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (4) | Register word offset |
| wdata_i | input | 32 | Write data |
| req_cpu_i | input | 2 | ID of the CPU making the access |
| rdata_o | output | 32 | Combinational read data |
| tick_i | input | 1 | Timer tick, posts a timer interrupt to all CPUs |
| dev_irq_i | input | 1 | Shared device interrupt |
| ipi_irq_o | output | NCPU (4) | Per-CPU IPI lines |
| tmr_irq_o | output | NCPU (4) | Per-CPU timer lines |
| dev_irq_o | output | NCPU (4) | Per-CPU device lines |
| warn_o | output | 1 | Redundant post or clear seen on the last write |
| err_o | output | 1 | Malformed write seen on the last write |

## Verification
The pending lines and the warning and error flags are registered. Each is due one edge after the write or tick that caused it. The bench drives every stimulus at a falling edge, lets one rising edge pass, and compares at the next falling edge, before it drives again. Read data and the device lines are combinational. The bench therefore compares them at the same falling edge at which it set the address or `dev_irq_i`. Table rows without a write confirm that a flag from the row before has dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int MAX_CPU  = 4;
  localparam int FIELD_W  = 4;
  localparam int DATA_W   = 32;
  localparam int CPUID_W  = $clog2(MAX_CPU);

  // field positions inside the control register
  localparam int POST_LSB = 12;
  localparam int ICLR_LSB = 8;
  localparam int TCLR_LSB = 4;
  localparam int ACK_BIT  = 28;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_IPI  = 2'd1,
    REG_TMR  = 2'd2,
    REG_REQ  = 2'd3
  } reg_idx_e;

  // IPI bits that a post finds already set, or a clear finds already empty
  function automatic logic [FIELD_W-1:0] f_ipi_redundant(
      input logic [FIELD_W-1:0] cur,
      input logic [FIELD_W-1:0] post,
      input logic [FIELD_W-1:0] clr);
    return (post & cur) | (clr & ~(cur | post));
  endfunction

  // control write that carries no action at all
  function automatic logic f_ctrl_empty(input logic [DATA_W-1:0] wd);
    return (wd[POST_LSB +: FIELD_W] == '0) && (wd[ICLR_LSB +: FIELD_W] == '0) &&
           (wd[TCLR_LSB +: FIELD_W] == '0) && !wd[ACK_BIT];
  endfunction
endpackage

// File: rtl/irqc_wr_decode.sv
module irqc_wr_decode
  import irqc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [3:0]        sel_o,
  output logic [NCPU-1:0]   post_o,
  output logic [NCPU-1:0]   iclr_o,
  output logic [NCPU-1:0]   tclr_o,
  output logic              bad_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [FIELD_W-1:0] f_post, f_iclr, f_tclr, f_low;
  logic [3:0]         wsel;
  logic               mapped;
  logic               unused_bits;

  assign unused_bits = ^{wdata_i[DATA_W-1:ACK_BIT+1], wdata_i[ACK_BIT-1:16]};

  assign mapped = (addr_i[ADDR_W-1:2] == {HI_W{1'b0}});

  always_comb begin
    sel_o = '0;
    if (mapped) sel_o[addr_i[1:0]] = 1'b1;
  end

  assign wsel = wr_en_i ? sel_o : 4'b0;

  assign f_low = wdata_i[FIELD_W-1:0];

  always_comb begin
    f_post = '0;
    f_iclr = '0;
    f_tclr = '0;
    if (wsel[REG_CTRL]) begin
      f_post = wdata_i[POST_LSB +: FIELD_W];
      f_iclr = wdata_i[ICLR_LSB +: FIELD_W];
      f_tclr = wdata_i[TCLR_LSB +: FIELD_W];
    end
    if (wsel[REG_IPI]) f_iclr = f_low;
    if (wsel[REG_TMR]) f_tclr = f_low;
    if (wsel[REG_REQ]) f_post = f_low;
  end

  // mask bits beyond the configured CPU count are dropped
  assign post_o = f_post[NCPU-1:0];
  assign iclr_o = f_iclr[NCPU-1:0];
  assign tclr_o = f_tclr[NCPU-1:0];

  always_comb begin
    bad_o = 1'b0;
    if (wr_en_i) begin
      if (!mapped)               bad_o = 1'b1;
      else if (wsel[REG_CTRL])   bad_o = f_ctrl_empty(wdata_i);
      else                       bad_o = (f_low == '0);
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)) else $error("register select not one-hot"); // R6

  AST_UNMAPPED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mapped) |-> (bad_o && post_o == '0 && iclr_o == '0 && tclr_o == '0))
    else $error("unmapped write not flagged"); // R7
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int NCPU     = 4,
  parameter bit SET_WINS = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCPU-1:0] set_i,
  input  logic [NCPU-1:0] clr_i,
  output logic [NCPU-1:0] pend_o
);
  for (genvar i = 0; i < NCPU; i++) begin : g_bit
    logic nxt;
    if (SET_WINS) begin : g_setwin
      assign nxt = set_i[i] | (pend_o[i] & ~clr_i[i]);
    end else begin : g_clrwin
      assign nxt = (pend_o[i] | set_i[i]) & ~clr_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= nxt;
    end

    AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && (SET_WINS || !clr_i[i])) |=> pend_o[i])
      else $error("set did not raise pending bit"); // R2

    AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !(SET_WINS && set_i[i])) |=> !pend_o[i])
      else $error("clear did not drop pending bit"); // R2

    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(pend_o[i]))
      else $error("pending bit moved without cause"); // R10
  end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import irqc_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [1:0]         req_cpu_i,
  output logic [31:0]        rdata_o,
  input  logic               tick_i,
  input  logic               dev_irq_i,
  output logic [NCPU-1:0]    ipi_irq_o,
  output logic [NCPU-1:0]    tmr_irq_o,
  output logic [NCPU-1:0]    dev_irq_o,
  output logic               warn_o,
  output logic               err_o
);
  localparam int PAD_W = FIELD_W - NCPU;

  logic [3:0]         sel;
  logic [NCPU-1:0]    post, iclr, tclr;
  logic               bad;
  logic [NCPU-1:0]    ipi_pend, tmr_pend;
  logic [FIELD_W-1:0] ipi_w, tmr_w, redundant;

  irqc_wr_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sel_o   (sel),
    .post_o  (post),
    .iclr_o  (iclr),
    .tclr_o  (tclr),
    .bad_o   (bad)
  );

  irqc_pend_bank #(.NCPU(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (post),
    .clr_i  (iclr),
    .pend_o (ipi_pend)
  );

  irqc_pend_bank #(.NCPU(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({NCPU{tick_i}}),
    .clr_i  (tclr),
    .pend_o (tmr_pend)
  );

  if (PAD_W > 0) begin : g_pad
    assign ipi_w = {{PAD_W{1'b0}}, ipi_pend};
    assign tmr_w = {{PAD_W{1'b0}}, tmr_pend};
    assign redundant = f_ipi_redundant(ipi_w, {{PAD_W{1'b0}}, post}, {{PAD_W{1'b0}}, iclr});
  end else begin : g_full
    assign ipi_w = ipi_pend;
    assign tmr_w = tmr_pend;
    assign redundant = f_ipi_redundant(ipi_w, post, iclr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      warn_o <= |redundant;
      err_o  <= bad;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel[REG_CTRL]: begin
        rdata_o[ICLR_LSB +: FIELD_W] = ipi_w;
        rdata_o[TCLR_LSB +: FIELD_W] = tmr_w;
        rdata_o[CPUID_W-1:0]         = req_cpu_i;
      end
      sel[REG_IPI]: rdata_o[FIELD_W-1:0] = ipi_w;
      sel[REG_TMR]: rdata_o[FIELD_W-1:0] = tmr_w;
      default:      rdata_o = '0;
    endcase
  end

  assign ipi_irq_o = ipi_pend;
  assign tmr_irq_o = tmr_pend;
  assign dev_irq_o = {NCPU{dev_irq_i}};

  AST_TICK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (&tmr_irq_o))
    else $error("tick did not reach every CPU"); // R4

  AST_ERR_NO_IPI_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> $stable(ipi_irq_o))
    else $error("malformed write altered IPI state"); // R7

  AST_WARN_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && post == '0 && iclr != '0 && (iclr & ipi_pend) == '0) |=> (warn_o && $stable(ipi_irq_o)))
    else $error("redundant clear mishandled"); // R3
endmodule

// File: tb/ipi_timer_intc_tb.sv
module ipi_timer_intc_tb;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        dev_in = 1'b0;
  logic [3:0]  ipi, tmr, dev;
  logic        warn, err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ipi_timer_intc #(.NCPU(NCPU), .ADDR_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .req_cpu_i(req_cpu), .rdata_o(rdata), .tick_i(tick), .dev_irq_i(dev_in),
    .ipi_irq_o(ipi), .tmr_irq_o(tmr), .dev_irq_o(dev), .warn_o(warn), .err_o(err)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [31:0] d;
    logic        tk;
    logic [3:0]  e_ipi;
    logic [3:0]  e_tmr;
    logic        e_warn;
    logic        e_err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd0, 32'h0000_F000, 1'b0, 4'hF, 4'h0, 1'b0, 1'b0}, // R2 post all
    '{1'b0, 4'd0, 32'h0,         1'b1, 4'hF, 4'hF, 1'b0, 1'b0}, // R4 tick
    '{1'b1, 4'd0, 32'h0000_1000, 1'b0, 4'hF, 4'hF, 1'b1, 1'b0}, // R3 repost
    '{1'b1, 4'd0, 32'h0000_0300, 1'b0, 4'hC, 4'hF, 1'b0, 1'b0}, // R2 clear ipi
    '{1'b1, 4'd0, 32'h0000_0100, 1'b0, 4'hC, 4'hF, 1'b1, 1'b0}, // R3 clear empty
    '{1'b1, 4'd0, 32'h0000_0050, 1'b0, 4'hC, 4'hA, 1'b0, 1'b0}, // R2 clear timer
    '{1'b1, 4'd0, 32'h1000_0000, 1'b0, 4'hC, 4'hA, 1'b0, 1'b0}, // R5 ack
    '{1'b1, 4'd0, 32'h0000_0000, 1'b0, 4'hC, 4'hA, 1'b0, 1'b1}, // R5 empty
    '{1'b0, 4'd0, 32'h0,         1'b0, 4'hC, 4'hA, 1'b0, 1'b0}, // R10 drop
    '{1'b1, 4'd3, 32'h0000_0003, 1'b0, 4'hF, 4'hA, 1'b0, 1'b0}, // R6 req
    '{1'b1, 4'd1, 32'h0000_0008, 1'b0, 4'h7, 4'hA, 1'b0, 1'b0}, // R6 ipi clr
    '{1'b1, 4'd2, 32'h0000_0002, 1'b0, 4'h7, 4'h8, 1'b0, 1'b0}, // R6 tmr clr
    '{1'b1, 4'd3, 32'hFFFF_FFF0, 1'b0, 4'h7, 4'h8, 1'b0, 1'b1}, // R7 zero mask
    '{1'b1, 4'd5, 32'h0000_000F, 1'b0, 4'h7, 4'h8, 1'b0, 1'b1}, // R7 unmapped
    '{1'b1, 4'd0, 32'h0000_1100, 1'b0, 4'h6, 4'h8, 1'b1, 1'b0}, // R2 post+clr pending
    '{1'b1, 4'd0, 32'h0000_1100, 1'b0, 4'h6, 4'h8, 1'b0, 1'b0}, // R2 post+clr idle
    '{1'b1, 4'd2, 32'h0000_0008, 1'b1, 4'h6, 4'hF, 1'b0, 1'b0}, // R4 tick wins
    '{1'b1, 4'd0, 32'h0000_82F0, 1'b0, 4'hC, 4'h0, 1'b0, 1'b0}  // R2 all fields
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0;
    tick  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ipi", {28'b0, ipi}, 32'h0);
    chk("R1 tmr", {28'b0, tmr}, 32'h0);
    chk("R1 flags", {30'b0, warn, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      wr_en = TBL[k].wr;
      addr  = TBL[k].a;
      wdata = TBL[k].d;
      tick  = TBL[k].tk;
      @(posedge clk);
      @(negedge clk);
      idle();
      chk($sformatf("R2/R3/R4 row %0d ipi", k), {28'b0, ipi}, {28'b0, TBL[k].e_ipi});
      chk($sformatf("R2/R4/R6 row %0d tmr", k), {28'b0, tmr}, {28'b0, TBL[k].e_tmr});
      chk($sformatf("R3/R10 row %0d warn", k), {31'b0, warn}, {31'b0, TBL[k].e_warn});
      chk($sformatf("R5/R7 row %0d err", k), {31'b0, err}, {31'b0, TBL[k].e_err});
    end

    // R8 control readback with requester ID; state is ipi=C tmr=0
    addr = 4'd0; req_cpu = 2'd2; #1;
    chk("R8 ctrl read", rdata, 32'h0000_0C02);
    req_cpu = 2'd1; #1;
    chk("R8 ctrl read cpu1", rdata, 32'h0000_0C01);
    addr = 4'd1; #1;
    chk("R6 ipi read", rdata, 32'h0000_000C);
    addr = 4'd2; #1;
    chk("R6 tmr read", rdata, 32'h0000_0000);
    addr = 4'd3; #1;
    chk("R6 req read", rdata, 32'h0000_0000);
    addr = 4'd9; #1;
    chk("R8 unmapped read", rdata, 32'h0000_0000);

    // R9 device lines
    dev_in = 1'b1; #1;
    chk("R9 dev high", {28'b0, dev}, 32'hF);
    dev_in = 1'b0; #1;
    chk("R9 dev low", {28'b0, dev}, 32'h0);

    // R11 high mask bits ignored on the dedicated request (bits 7:4 are not a CPU)
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd3; wdata = 32'h0000_00F2;
    @(posedge clk); @(negedge clk); idle();
    chk("R11 req mask", {28'b0, ipi}, 32'hE);
    chk("R11 no warn", {31'b0, warn}, 32'h0);

    // R10 write strobe low: no effect
    addr = 4'd0; wdata = 32'h0000_0F00;
    @(posedge clk); @(negedge clk);
    chk("R10 no strobe", {28'b0, ipi}, 32'hE);

    // R1 reset mid-run
    tick = 1'b1; @(posedge clk); @(negedge clk); idle();
    rst_n = 1'b0; #1;
    chk("R1 reset ipi", {28'b0, ipi}, 32'h0);
    chk("R1 reset tmr", {28'b0, tmr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule